// File: doc/BRIEF.md
# Byte-Lane Address Router for a 16-bit CPU Bus

This block sits between a CPU core and the storage it addresses over a 16-bit address, byte-wide bus. Each access is decoded against four fixed windows: a 32 KiB read-only program window, an 8 KiB tile-data RAM, an 8 KiB work RAM and a twelve-byte stub window for display registers. Reads resolve to the first window in priority order (program, tile, work, display) that contains the address. A read that matches no window is answered with a fault instead of data. Writes go to every matching window. The program window and the display stub accept writes and drop them.

An access can be narrow (one byte) or wide (two bytes). A wide access treats the 16-bit value as little-endian: the low byte lives at the address and the high byte at the address plus one. Each byte lane is decoded on its own, so a wide access can straddle two windows. The program image is a computed pattern, so it needs no storage. The two RAMs are on-chip arrays cleared by reset. `RAM_AW` sets how many offset bits index each RAM; at its default of 9, each RAM holds 512 bytes, and its 8 KiB window aliases onto them.

A response state machine produces the handshake outputs. It has four states:
- `ST_IDLE`: no response this cycle.
- `ST_DATA`: read data valid.
- `ST_FAULT`: fault raised by the read in the previous cycle.
- `ST_FAULT_HOLD`: fault still standing with no new read.

Its transitions are:
- `go_data`: a read that resolves, from any state, enters `ST_DATA`.
- `go_fault`: a read that does not resolve, from any state, enters `ST_FAULT`.
- `settle`: from `ST_DATA` or `ST_IDLE` with no read, enters `ST_IDLE`.
- `hold`: from a fault state with no read and no accepted write, enters `ST_FAULT_HOLD`.
- `clear`: from a fault state with an accepted write and no read, enters `ST_IDLE`.

Top module: `mmio_router`

## Requirements
- R1: While reset is held and in the cycle after it is released, cpu_rvalid, cpu_err and cpu_rdata are 0. Every byte of both RAMs reads as 0x00 after reset, including bytes written before the reset.
- R2: A read (cpu_rd high at a clock edge) that resolves raises cpu_rvalid for exactly the one cycle after that edge, with cpu_rdata valid in that cycle. A cycle without a read is followed by cpu_rvalid low.
- R3: Addresses 0x0000–0x7FFF read the program pattern: the byte at offset k is k[7:0] XOR k[14:7]. Writes there are accepted, change nothing and raise no fault.
- R4: Addresses 0x8000–0x9FFF are the tile RAM. It is indexed by the low RAM_AW bits of (address − 0x8000), so two addresses 2^RAM_AW apart name the same byte.
- R5: Addresses 0xC000–0xDFFF are the work RAM, indexed by the low RAM_AW bits of (address − 0xC000). It is separate from the tile RAM.
- R6: Addresses 0xFF40–0xFF4B read as 0x00. Writes there are accepted, have no effect and raise no fault.
- R7: A read of an address outside all windows gives no cpu_rvalid and sets cpu_rdata to 0. cpu_err rises in the cycle after that read. cpu_err then stays high until a resolving read or an accepted write, and falls in the cycle after that access.
- R8: With cpu_wide high, lane 0 uses the address and cpu_wdata[7:0]/cpu_rdata[7:0], and lane 1 uses address+1 and cpu_wdata[15:8]/cpu_rdata[15:8]. A narrow read returns 0x00 in cpu_rdata[15:8].
- R9: Each lane is decoded on its own. On a wide write whose address+1 is unmapped, the low byte is stored and the high byte is dropped. A wide read with either lane unmapped faults as in R7.
- R10: When read and write hit the same address in one cycle, the read returns the contents from before the write, and the write takes effect.
- R11: cpu_rvalid and cpu_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 16 | Write data; the high byte is used only when cpu_wide is high |
| cpu_rd | input | 1 | Read request for this cycle |
| cpu_wr | input | 1 | Write request for this cycle |
| cpu_wide | input | 1 | Two-byte little-endian access |
| cpu_rdata | output | 16 | Registered read data |
| cpu_rvalid | output | 1 | One-cycle pulse: cpu_rdata holds a resolved read |
| cpu_err | output | 1 | Fault flag for an unmapped read, held until the next successful access |

## Verification
Every result is due exactly one cycle after the edge that samples its request. cpu_rvalid, cpu_rdata and a newly raised cpu_err appear after that single edge. A clearing access lowers cpu_err after the same one edge. A write becomes visible to a read issued in the following cycle. A read issued in the same cycle as a write sees the old byte.

The driver applies one stimulus per cycle, shortly after the falling edge. For every cycle it pushes the expected response, taken from a reference model of the windows and the fault flag, into a queue. The monitor pops one item at each falling edge, which is half a cycle after the edge that produced the response.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int ADDR_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 15;
    localparam int N_REGION = 4;
    localparam int N_LANE   = 2;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_PROG = 3'd1,
        RG_TILE = 3'd2,
        RG_WORK = 3'd3,
        RG_DISP = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_FAULT,
        ST_FAULT_HOLD
    } resp_state_e;

    // Window table, listed in read priority order (index 0 wins)
    function automatic logic [ADDR_W-1:0] region_lo(input int idx);
        case (idx)
            0:       return 16'h0000;
            1:       return 16'h8000;
            2:       return 16'hC000;
            default: return 16'hFF40;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] region_hi(input int idx);
        case (idx)
            0:       return 16'h7FFF;
            1:       return 16'h9FFF;
            2:       return 16'hDFFF;
            default: return 16'hFF4B;
        endcase
    endfunction

    function automatic region_e region_tag(input int idx);
        case (idx)
            0:       return RG_PROG;
            1:       return RG_TILE;
            2:       return RG_WORK;
            default: return RG_DISP;
        endcase
    endfunction

    // Program image, computed from the offset
    function automatic logic [BYTE_W-1:0] prog_byte(input logic [OFF_W-1:0] k);
        return k[7:0] ^ k[14:7];
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [OFF_W-1:0]  offset,
    output logic              hit
);

    logic [N_REGION-1:0] match;
    logic [ADDR_W-1:0]   rel    [N_REGION];
    region_e             tag_c  [N_REGION];

    for (genvar i = 0; i < N_REGION; i++) begin : g_win
        localparam logic [ADDR_W-1:0] WIN_LO   = region_lo(i);
        localparam logic [ADDR_W-1:0] WIN_SPAN = region_hi(i) - region_lo(i);
        localparam region_e           WIN_TAG  = region_tag(i);
        assign rel[i]   = addr - WIN_LO;
        assign match[i] = (rel[i] <= WIN_SPAN);
        assign tag_c[i] = WIN_TAG;
    end

    // Lowest index wins: scan from the back so earlier windows override
    always_comb begin
        region = RG_NONE;
        offset = '0;
        hit    = 1'b0;
        for (int i = N_REGION - 1; i >= 0; i--) begin
            if (match[i]) begin
                region = tag_c[i];
                offset = rel[i][OFF_W-1:0];
                hit    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
    parameter int AW = 9,
    parameter int DW = 8,
    parameter int NP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  idx,
    input  logic [NP-1:0][DW-1:0]  wdat,
    output logic [NP-1:0][DW-1:0]  rdat
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (we[p]) begin
                    mem[idx[p]] <= wdat[p];
                end
            end
        end
    end

    // Read is asynchronous, so a same-cycle write is not yet visible
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            rdat[p] = mem[idx[p]];
        end
    end

    // R4: a lane-0 write lands at its index
    p_store_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> mem[$past(idx[0])] == $past(wdat[0]));

endmodule

// File: rtl/mmio_resp_fsm.sv
module mmio_resp_fsm
    import mmio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic rd_ok,
    input  logic wr_ok,
    output logic rvalid,
    output logic err
);

    resp_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_DATA:        state_nxt = ST_IDLE;                         // settle
            ST_FAULT, ST_FAULT_HOLD: state_nxt = wr_ok ? ST_IDLE : ST_FAULT_HOLD; // clear / hold
        endcase
        if (rd) begin
            state_nxt = rd_ok ? ST_DATA : ST_FAULT;                               // go_data / go_fault
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_DATA:       rvalid = 1'b1;
            ST_FAULT:      err    = 1'b1;
            ST_FAULT_HOLD: err    = 1'b1;
        endcase
    end

    p_data_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd && rd_ok |=> rvalid && !err);

    p_fault_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !rd_ok |=> err && !rvalid);

    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err && !rd && !wr_ok |=> err);

endmodule

// File: rtl/mmio_router.sv
module mmio_router
    import mmio_pkg::*;
#(
    parameter int RAM_AW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] cpu_wdata,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic        cpu_wide,
    output logic [15:0] cpu_rdata,
    output logic        cpu_rvalid,
    output logic        cpu_err
);

    localparam int N_RAM = 2;

    logic [ADDR_W-1:0]              lane_addr  [N_LANE];
    logic                           lane_on    [N_LANE];
    logic [BYTE_W-1:0]              lane_wdata [N_LANE];
    region_e                        lane_region[N_LANE];
    logic [OFF_W-1:0]               lane_off   [N_LANE];
    logic                           lane_hit   [N_LANE];
    logic [BYTE_W-1:0]              lane_byte  [N_LANE];
    logic [N_LANE-1:0][BYTE_W-1:0]  ram_rd     [N_RAM];

    logic        rd_ok;
    logic        wr_ok;
    logic [15:0] rdata_q;

    assign lane_addr[0]  = cpu_addr;
    assign lane_addr[1]  = cpu_addr + 16'd1;
    assign lane_on[0]    = 1'b1;
    assign lane_on[1]    = cpu_wide;
    assign lane_wdata[0] = cpu_wdata[7:0];
    assign lane_wdata[1] = cpu_wdata[15:8];

    for (genvar p = 0; p < N_LANE; p++) begin : g_lane
        mmio_decode u_dec (
            .addr   (lane_addr[p]),
            .region (lane_region[p]),
            .offset (lane_off[p]),
            .hit    (lane_hit[p])
        );
    end

    for (genvar k = 0; k < N_RAM; k++) begin : g_ram
        localparam region_e OWN = (k == 0) ? RG_TILE : RG_WORK;
        logic [N_LANE-1:0]             we;
        logic [N_LANE-1:0][RAM_AW-1:0] idx;
        logic [N_LANE-1:0][BYTE_W-1:0] wdat;
        always_comb begin
            for (int p = 0; p < N_LANE; p++) begin
                we[p]   = cpu_wr && lane_on[p] && (lane_region[p] == OWN);
                idx[p]  = lane_off[p][RAM_AW-1:0];
                wdat[p] = lane_wdata[p];
            end
        end
        mmio_ram #(.AW(RAM_AW), .DW(BYTE_W), .NP(N_LANE)) u_ram (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (we),
            .idx  (idx),
            .wdat (wdat),
            .rdat (ram_rd[k])
        );
    end

    always_comb begin
        for (int p = 0; p < N_LANE; p++) begin
            unique case (lane_region[p])
                RG_PROG: lane_byte[p] = prog_byte(lane_off[p]);
                RG_TILE: lane_byte[p] = ram_rd[0][p];
                RG_WORK: lane_byte[p] = ram_rd[1][p];
                RG_DISP: lane_byte[p] = '0;
                default: lane_byte[p] = '0;
            endcase
        end
    end

    assign rd_ok = lane_hit[0] && (!cpu_wide || lane_hit[1]);
    assign wr_ok = cpu_wr && lane_hit[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cpu_rd) begin
            if (rd_ok) begin
                rdata_q <= {(cpu_wide ? lane_byte[1] : 8'h00), lane_byte[0]};
            end else begin
                rdata_q <= '0;
            end
        end
    end

    mmio_resp_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (cpu_rd),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok),
        .rvalid(cpu_rvalid),
        .err   (cpu_err)
    );

    assign cpu_rdata = rdata_q;

    p_prog_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && !cpu_wide && lane_region[0] == RG_PROG
        |=> cpu_rdata == {8'h00, $past(cpu_addr[7:0]) ^ $past(cpu_addr[14:7])});

    p_disp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && lane_region[0] == RG_DISP |=> cpu_rdata[7:0] == 8'h00);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> !cpu_rvalid);

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rvalid && cpu_err));

endmodule

// File: tb/mmio_router_bench.sv
`timescale 1ns/1ps
module mmio_router_bench;

    localparam int RAM_AW = 9;
    localparam int DEPTH  = 1 << RAM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_wide = 1'b0;
    logic [15:0] cpu_rdata;
    logic        cpu_rvalid;
    logic        cpu_err;

    always #2.5 clk = ~clk;

    mmio_router #(.RAM_AW(RAM_AW)) u_mmio_router (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wide(cpu_wide),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_err(cpu_err)
    );

    typedef struct {
        logic        rv;
        logic        er;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    logic [7:0] tile_m [DEPTH];
    logic [7:0] work_m [DEPTH];
    logic       err_m = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // 0 none, 1 program, 2 tile, 3 work, 4 display
    function automatic int win_of(input logic [15:0] a);
        if (a <= 16'h7FFF) return 1;
        if (a >= 16'h8000 && a <= 16'h9FFF) return 2;
        if (a >= 16'hC000 && a <= 16'hDFFF) return 3;
        if (a >= 16'hFF40 && a <= 16'hFF4B) return 4;
        return 0;
    endfunction

    function automatic logic [7:0] model_byte(input logic [15:0] a);
        logic [15:0] k;
        case (win_of(a))
            1: begin k = a; return k[7:0] ^ k[14:7]; end
            2: begin k = a - 16'h8000; return tile_m[k[RAM_AW-1:0]]; end
            3: begin k = a - 16'hC000; return work_m[k[RAM_AW-1:0]]; end
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] k;
        case (win_of(a))
            2: begin k = a - 16'h8000; tile_m[k[RAM_AW-1:0]] = d; end
            3: begin k = a - 16'hC000; work_m[k[RAM_AW-1:0]] = d; end
            default: ;
        endcase
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            tile_m[i] = 8'h00;
            work_m[i] = 8'h00;
        end
        err_m = 1'b0;
    endtask

    task automatic access(input bit rd, input bit wr, input bit wide,
                          input logic [15:0] a, input logic [15:0] wd, input string tag);
        exp_t e;
        logic [15:0] a1;
        bit ok;
        @(negedge clk);
        #1;
        cpu_rd = rd; cpu_wr = wr; cpu_wide = wide; cpu_addr = a; cpu_wdata = wd;
        a1 = a + 16'd1;
        ok = (win_of(a) != 0) && (!wide || win_of(a1) != 0);
        e.tag = tag;
        e.rv  = rd && ok;
        e.data = 16'h0000;
        if (rd && ok) e.data = {(wide ? model_byte(a1) : 8'h00), model_byte(a)};
        if (rd) err_m = !ok;
        else if (wr && win_of(a) != 0) err_m = 1'b0;
        e.er = err_m;
        sbq.push_back(e);
        if (wr) begin
            model_write(a, wd[7:0]);
            if (wide) model_write(a1, wd[15:8]);
        end
    endtask

    task automatic rd8(input logic [15:0] a, input string tag);
        access(1, 0, 0, a, 16'h0, tag);
    endtask
    task automatic wr8(input logic [15:0] a, input logic [7:0] d, input string tag);
        access(0, 1, 0, a, {8'h00, d}, tag);
    endtask
    task automatic idle(input string tag);
        access(0, 0, 0, 16'h0, 16'h0, tag);
    endtask

    // Monitor: one expected item per cycle, compared half a cycle after the edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(cpu_rvalid == e.rv, {e.tag, " rvalid"}, {15'd0, cpu_rvalid}, {15'd0, e.rv});
            chk(cpu_err == e.er, {e.tag, " err"}, {15'd0, cpu_err}, {15'd0, e.er});
            chk(!(cpu_rvalid && cpu_err), "R11 rvalid/err exclusive",
                {14'd0, cpu_rvalid, cpu_err}, 16'h0);
            if (e.rv || (e.er && !e.rv && cpu_rvalid == 1'b0 && e.data == 16'h0 && e.tag.len() > 0 && e.tag[0] == "F"))
                chk(cpu_rdata == e.data, {e.tag, " data"}, cpu_rdata, e.data);
        end
    end

    task automatic do_reset();
        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0; cpu_wide = 0;
        repeat (3) @(negedge clk);
        chk(cpu_rvalid == 1'b0 && cpu_err == 1'b0 && cpu_rdata == 16'h0,
            "R1 outputs in reset", {cpu_rvalid, cpu_err, cpu_rdata[13:0]}, 16'h0);
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        model_clear();
        do_reset();
        idle("R1 idle after reset");
        rd8(16'h8000, "R1 tile zero");
        rd8(16'hC123, "R1 work zero");

        rd8(16'h0000, "R3 prog 0000");
        rd8(16'h1234, "R3 prog 1234");
        rd8(16'h7FFF, "R3 prog 7FFF");
        wr8(16'h1234, 8'hFF, "R3 prog write");
        rd8(16'h1234, "R3 prog unchanged");

        wr8(16'h8005, 8'hA5, "R4 tile write");
        rd8(16'h8005, "R4 tile read");
        wr8(16'h8205, 8'h3C, "R4 alias write");
        rd8(16'h8005, "R4 alias read");
        wr8(16'h9FFF, 8'h81, "R4 top write");
        rd8(16'h9FFF, "R4 top read");

        wr8(16'hC010, 8'h5A, "R5 work write");
        rd8(16'h8010, "R5 tile untouched");
        rd8(16'hC010, "R5 work read");

        rd8(16'hFF40, "R6 disp first");
        rd8(16'hFF4B, "R6 disp last");
        wr8(16'hFF45, 8'h12, "R6 disp write");
        rd8(16'hFF45, "R6 disp still zero");

        rd8(16'hA000, "F R7 unmapped A000");
        idle("R7 err holds");
        rd8(16'hFF4C, "F R7 unmapped FF4C");
        rd8(16'hE000, "F R7 unmapped E000");
        wr8(16'hC000, 8'h44, "R7 write clears");
        rd8(16'hFF3F, "F R7 unmapped FF3F");
        wr8(16'hB000, 8'h01, "R7 unmapped write keeps err");
        rd8(16'hC000, "R7 read clears");
        idle("R7 clear settled");

        access(0, 1, 1, 16'hC100, 16'hBEEF, "R8 wide write");
        rd8(16'hC100, "R8 low byte");
        rd8(16'hC101, "R8 high byte");
        access(1, 0, 1, 16'hC100, 16'h0, "R8 wide read");
        access(1, 0, 1, 16'h0100, 16'h0, "R8 wide prog read");

        access(0, 1, 1, 16'h9FFF, 16'h1122, "R9 straddle write");
        rd8(16'h9FFF, "R9 low stored");
        access(1, 0, 1, 16'h9FFF, 16'h0, "F R9 straddle read");
        access(1, 0, 1, 16'hDFFF, 16'h0, "F R9 work edge read");
        rd8(16'hDFFF, "R9 narrow at edge ok");

        access(1, 1, 0, 16'hC200, 16'h0077, "R10 read old");
        rd8(16'hC200, "R10 write landed");

        wr8(16'h8040, 8'h99, "R1 pre-reset write");
        rd8(16'h8040, "R1 pre-reset read");
        do_reset();
        rd8(16'h8040, "R1 cleared by reset");
        rd8(16'hC200, "R1 work cleared");
        idle("drain");
        idle("drain");

        while (sbq.size() > 0) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule